// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Logic

This block is the device side of a serial EEPROM that is reached over three wires: a select line, a serial clock and a data input. A fourth line carries data out and can be released. The block runs on a fast system clock. It brings the three inputs into that clock domain and detects the rising edges of the serial clock. On those edges it gathers a start bit, a two-bit opcode and an address field, then runs the command against a small internal array. The supported commands are read, write, erase, write-all, erase-all, enable-programming and disable-programming.

A programming command does not change the array at once. It is armed, and the self-timed program cycle starts when the select line goes low. A counter of system clocks stands in for the nonvolatile write time. While that counter runs, raising select shows a busy level on the data output, and a ready level once the cycle is over. Three parameters set the shape of the device: the word width (8 or 16), the width of the address field on the wire, and the number of address bits that actually index the array. Any address bits above the indexed ones are still clocked in but do not select a word. The whole-array commands are present only when a parameter enables them.

Top module: `threeWireEeprom`

## Requirements
- R1: Logic-0 bits on the data input while select is high are skipped. A command begins with the first logic-1 bit, which is the start bit, sampled on a rising serial-clock edge.
- R2: Opcode 10 is read. After the last address bit, the data output drives one 0 bit, then the addressed word, most significant bit first, one bit per rising edge.
- R3: A read keeps going while clocks continue: after the last bit of a word comes the next word, and the address wraps from the last word back to word 0.
- R4: Opcode 01 is write. The address is followed by a data word, most significant bit first. Once the program cycle ends, that word reads back at that address.
- R5: Opcode 11 is erase. The addressed word then reads as all ones.
- R6: Opcode 00 with the top two address bits at 11 sets the programming-enable latch. Opcode 00 with the top two address bits at 00 clears it. Reset leaves the latch cleared. While the latch is clear, write, erase, write-all and erase-all leave the array unchanged.
- R7: With whole-array commands enabled, opcode 00 with the top two address bits at 01 followed by a data word writes that word into every location. Opcode 00 with the top two address bits at 10 sets every location to all ones.
- R8: With whole-array commands disabled by parameter, write-all and erase-all leave the array unchanged.
- R9: The data output is released (output enable low) after reset, whenever select is low, and at all times other than read data or program status.
- R10: Select going low after an armed program command starts a cycle of the parameterised length. With select high, the output drives 0 while the cycle runs and 1 once it has ended.
- R11: Address-field bits above the indexed array width are don't-care but must still be clocked: an address that differs only in those bits reaches the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; array reset to all ones, latch cleared |
| csIn | input | 1 | Chip select, active high, asynchronous to clk |
| skIn | input | 1 | Serial clock; data input sampled on its rising edge |
| diIn | input | 1 | Serial data input |
| doData | output | 1 | Serial data output value |
| doOe | output | 1 | Output enable for the data output (0 = high impedance) |

## Verification
The bench writes a distinct value to every word, reads the whole array back in one continuous read that runs past the end, and so catches an address counter that fails to move on or wrap, or a shifter that loses or repeats a bit at a word boundary. Several cases are aimed at the enable latch. A write before any enable, and a write after disable, must leave the old word in place; a design with a latch that is stuck on or inverted would change it. A second instance with the whole-array commands disabled runs alongside the first. If the parameter gate were wrong, that instance's contents would change under write-all or erase-all. Further cases cover an aliased address that differs only in the don't-care bit, leading zeros before the start bit, and the busy-to-ready change on the output. These would expose a design that decodes too many address bits, miscounts the header, or reports ready before the cycle has ended.

// File: rtl/eepromPkg.sv
package eepromPkg;

  typedef enum logic [1:0] {
    PROG_WRITE = 2'd0,
    PROG_ERASE = 2'd1,
    PROG_WRALL = 2'd2,
    PROG_ERALL = 2'd3
  } progKind_t;

  typedef struct packed {
    logic      hdrShift;
    logic      dataShift;
    logic      rdLoad;
    logic      rdStep;
    logic      commit;
    progKind_t kind;
  } dpStrobe_t;

endpackage

// File: rtl/eepromCtrl.sv
module eepromCtrl
  import eepromPkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int ADDR_BITS   = 7,
  parameter int PROG_CYCLES = 1000,
  parameter bit ALLOW_BULK  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skIn,
  input  logic       diIn,
  input  logic [1:0] hdrOpcode,
  input  logic [1:0] hdrExt,
  input  logic       rdBit,
  output logic       diBit,
  output dpStrobe_t  stb,
  output logic       doData,
  output logic       doOe
);

  localparam int HDR_W = 2 + ADDR_BITS;
  localparam int MAX_W = (HDR_W > WORD_BITS) ? HDR_W : WORD_BITS;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_DECODE, ST_DATA, ST_READ,
    ST_SKIP, ST_ARMED, ST_BUSY, ST_DONE
  } ctlState_t;

  ctlState_t   state;
  logic [2:0]  syncA, syncB;
  logic        skPrev;
  logic        csS, skS, diS, skRise;
  logic [CNT_W-1:0] bitCnt;
  logic [TMR_W-1:0] progTimer;
  logic        wel;
  progKind_t   kind;
  logic        timerDone;

  // two-flop synchroniser for select, clock and data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      skPrev <= 1'b0;
    end else begin
      syncA  <= {csIn, skIn, diIn};
      syncB  <= syncA;
      skPrev <= syncB[1];
    end
  end

  assign csS    = syncB[2];
  assign skS    = syncB[1];
  assign diS    = syncB[0];
  assign skRise = skS && !skPrev;
  assign diBit  = diS;
  assign timerDone = (progTimer == TMR_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      progTimer <= '0;
      wel       <= 1'b0;
      kind      <= PROG_WRITE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (csS && skRise && diS) begin
            state  <= ST_HDR;
            bitCnt <= '0;
          end
        end
        ST_HDR: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(HDR_W - 1)) state <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (!csS) state <= ST_IDLE;
          else begin
            bitCnt <= '0;
            case (hdrOpcode)
              2'b10: state <= ST_READ;
              2'b01: begin
                kind  <= PROG_WRITE;
                state <= ST_DATA;
              end
              2'b11: begin
                kind  <= PROG_ERASE;
                state <= wel ? ST_ARMED : ST_SKIP;
              end
              default: begin
                case (hdrExt)
                  2'b11: begin
                    wel   <= 1'b1;
                    state <= ST_SKIP;
                  end
                  2'b00: begin
                    wel   <= 1'b0;
                    state <= ST_SKIP;
                  end
                  2'b01: begin
                    kind  <= PROG_WRALL;
                    state <= ST_DATA;
                  end
                  default: begin
                    kind  <= PROG_ERALL;
                    state <= (wel && ALLOW_BULK) ? ST_ARMED : ST_SKIP;
                  end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(WORD_BITS - 1))
              state <= (wel && (kind == PROG_WRITE || ALLOW_BULK)) ? ST_ARMED : ST_SKIP;
          end
        end
        ST_READ, ST_SKIP: begin
          if (!csS) state <= ST_IDLE;
        end
        ST_ARMED: begin
          if (!csS) begin
            state     <= ST_BUSY;
            progTimer <= '0;
          end
        end
        ST_BUSY: begin
          if (timerDone) state <= ST_DONE;
          else progTimer <= progTimer + 1'b1;
        end
        ST_DONE: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise && diS) begin
            state  <= ST_HDR;
            bitCnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.hdrShift  = (state == ST_HDR) && csS && skRise;
    stb.dataShift = (state == ST_DATA) && csS && skRise;
    stb.rdLoad    = (state == ST_DECODE) && csS && (hdrOpcode == 2'b10);
    stb.rdStep    = (state == ST_READ) && csS && skRise;
    stb.commit    = (state == ST_BUSY) && timerDone;
    stb.kind      = kind;
  end

  assign doOe   = (state == ST_READ) || (((state == ST_BUSY) || (state == ST_DONE)) && csS);
  assign doData = (state == ST_READ) ? rdBit : (state == ST_DONE);

  assert_start_on_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR && $past(state) == ST_IDLE) |-> $past(diS));

  assert_commit_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> wel);

  assert_bulk_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && (kind == PROG_WRALL || kind == PROG_ERALL)) |-> (ALLOW_BULK != 1'b0));

  assert_released_when_deselected_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!csS && !$past(csS)) |-> !doOe);

  assert_busy_shows_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && csS) |-> (doOe && !doData));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.hdrShift, stb.dataShift, stb.rdLoad, stb.rdStep, stb.commit}));

endmodule

// File: rtl/eepromDatapath.sv
module eepromDatapath
  import eepromPkg::*;
#(
  parameter int WORD_BITS     = 8,
  parameter int ADDR_BITS     = 7,
  parameter int MEM_ADDR_BITS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       diBit,
  output logic [1:0] hdrOpcode,
  output logic [1:0] hdrExt,
  output logic       rdBit
);

  localparam int HDR_W  = 2 + ADDR_BITS;
  localparam int DEPTH  = 1 << MEM_ADDR_BITS;
  localparam int LEFT_W = $clog2(WORD_BITS + 1);

  logic [HDR_W-1:0]         hdrReg;
  logic [WORD_BITS-1:0]     dataReg;
  logic [WORD_BITS-1:0]     mem [DEPTH];
  logic [WORD_BITS-1:0]     rdShift;
  logic [MEM_ADDR_BITS-1:0] rdAddr;
  logic [LEFT_W-1:0]        rdLeft;
  logic [MEM_ADDR_BITS-1:0] wordAddr;
  logic                     isBulk, isErase;
  logic [WORD_BITS-1:0]     fillWord;

  assign hdrOpcode = hdrReg[HDR_W-1 -: 2];
  assign hdrExt    = hdrReg[ADDR_BITS-1 -: 2];
  assign wordAddr  = hdrReg[MEM_ADDR_BITS-1:0];
  assign isBulk    = (stb.kind == PROG_WRALL) || (stb.kind == PROG_ERALL);
  assign isErase   = (stb.kind == PROG_ERASE) || (stb.kind == PROG_ERALL);
  assign fillWord  = isErase ? '1 : dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg  <= '0;
      dataReg <= '0;
    end else begin
      if (stb.hdrShift)  hdrReg  <= {hdrReg[HDR_W-2:0], diBit};
      if (stb.dataShift) dataReg <= {dataReg[WORD_BITS-2:0], diBit};
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[i] <= '1;
      else if (stb.commit && (isBulk || wordAddr == MEM_ADDR_BITS'(i))) mem[i] <= fillWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
      rdAddr  <= '0;
      rdLeft  <= LEFT_W'(WORD_BITS);
      rdBit   <= 1'b0;
    end else if (stb.rdLoad) begin
      rdShift <= mem[wordAddr];
      rdAddr  <= wordAddr + 1'b1;
      rdLeft  <= LEFT_W'(WORD_BITS);
      rdBit   <= 1'b0;
    end else if (stb.rdStep) begin
      rdBit <= rdShift[WORD_BITS-1];
      if (rdLeft == LEFT_W'(1)) begin
        rdShift <= mem[rdAddr];
        rdAddr  <= rdAddr + 1'b1;
        rdLeft  <= LEFT_W'(WORD_BITS);
      end else begin
        rdShift <= rdShift << 1;
        rdLeft  <= rdLeft - 1'b1;
      end
    end
  end

  assert_read_count_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdLeft != '0) && (rdLeft <= LEFT_W'(WORD_BITS)));

endmodule

// File: rtl/threeWireEeprom.sv
module threeWireEeprom
  import eepromPkg::*;
#(
  parameter int WORD_BITS     = 8,
  parameter int ADDR_BITS     = 7,
  parameter int MEM_ADDR_BITS = 6,
  parameter int PROG_CYCLES   = 1000,
  parameter bit ALLOW_BULK    = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doData,
  output logic doOe
);

  dpStrobe_t  stb;
  logic [1:0] hdrOpcode;
  logic [1:0] hdrExt;
  logic       rdBit;
  logic       diBit;

  eepromCtrl #(
    .WORD_BITS  (WORD_BITS),
    .ADDR_BITS  (ADDR_BITS),
    .PROG_CYCLES(PROG_CYCLES),
    .ALLOW_BULK (ALLOW_BULK)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csIn     (csIn),
    .skIn     (skIn),
    .diIn     (diIn),
    .hdrOpcode(hdrOpcode),
    .hdrExt   (hdrExt),
    .rdBit    (rdBit),
    .diBit    (diBit),
    .stb      (stb),
    .doData   (doData),
    .doOe     (doOe)
  );

  eepromDatapath #(
    .WORD_BITS    (WORD_BITS),
    .ADDR_BITS    (ADDR_BITS),
    .MEM_ADDR_BITS(MEM_ADDR_BITS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .diBit    (diBit),
    .hdrOpcode(hdrOpcode),
    .hdrExt   (hdrExt),
    .rdBit    (rdBit)
  );

endmodule

// File: tb/sim_threeWireEeprom.sv
module sim_threeWireEeprom;

  localparam int WB    = 8;
  localparam int AB    = 7;
  localparam int MB    = 6;
  localparam int PC    = 40;
  localparam int H     = 6;
  localparam int DEPTH = 1 << MB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do0, oe0, do1, oe1;
  logic lastDo0, lastOe0, lastDo1, lastOe1;
  int   errs = 0;
  int   checks = 0;
  logic [WB-1:0] m0 [DEPTH];
  logic [WB-1:0] m1 [DEPTH];
  logic [WB-1:0] r0 [DEPTH+2];
  logic [WB-1:0] r1 [DEPTH+2];

  always #4 clk = ~clk;

  threeWireEeprom #(.WORD_BITS(WB), .ADDR_BITS(AB), .MEM_ADDR_BITS(MB),
                    .PROG_CYCLES(PC), .ALLOW_BULK(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doData(do0), .doOe(oe0));

  threeWireEeprom #(.WORD_BITS(WB), .ADDR_BITS(AB), .MEM_ADDR_BITS(MB),
                    .PROG_CYCLES(PC), .ALLOW_BULK(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doData(do1), .doOe(oe1));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WB-1:0] pat(input int a);
    return WB'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic bitIo(input logic b);
    di = b;
    repeat (H) @(negedge clk);
    sk = 1'b1;
    repeat (H) @(negedge clk);
    lastDo0 = do0; lastOe0 = oe0;
    lastDo1 = do1; lastOe1 = oe1;
    sk = 1'b0;
  endtask

  task automatic sendHdr(input logic [1:0] op, input logic [AB-1:0] a, input int lead);
    cs = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < lead; i++) bitIo(1'b0);
    bitIo(1'b1);
    bitIo(op[1]);
    bitIo(op[0]);
    for (int i = AB - 1; i >= 0; i--) bitIo(a[i]);
  endtask

  task automatic sendWord(input logic [WB-1:0] d);
    for (int i = WB - 1; i >= 0; i--) bitIo(d[i]);
  endtask

  task automatic csDown();
    cs = 1'b0;
    di = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic waitProg();
    repeat (PC + 12) @(negedge clk);
  endtask

  task automatic readRun(input logic [AB-1:0] a, input int n, input int lead);
    sendHdr(2'b10, a, lead);
    // R2: dummy zero driven after the last address bit
    check(lastOe0 && !lastDo0, "R2 dummy bit u0", {lastOe0, lastDo0}, 2);
    check(lastOe1 && !lastDo1, "R2 dummy bit u1", {lastOe1, lastDo1}, 2);
    for (int w = 0; w < n; w++) begin
      for (int i = WB - 1; i >= 0; i--) begin
        bitIo(1'b0);
        r0[w][i] = lastDo0;
        r1[w][i] = lastDo1;
      end
    end
    csDown();
  endtask

  task automatic doWrite(input logic [AB-1:0] a, input logic [WB-1:0] d);
    sendHdr(2'b01, a, 0);
    sendWord(d);
    csDown();
    waitProg();
  endtask

  task automatic extCmd(input logic [1:0] sel);
    sendHdr(2'b00, {sel, {(AB-2){1'b0}}}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m0[i] = '1;
      m1[i] = '1;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!oe0 && !oe1, "R9 released after reset", {oe0, oe1}, 0);

    // erased array reads all ones
    readRun(7'd0, 1, 0);
    check(r0[0] == 8'hFF, "R2 read erased word", r0[0], 8'hFF);
    check(!oe0, "R9 released after read", oe0, 0);

    // R6: latch cleared at reset, write ignored
    doWrite(7'd5, 8'h12);
    readRun(7'd5, 1, 0);
    check(r0[0] == m0[5], "R6 write while locked", r0[0], m0[5]);

    extCmd(2'b11);
    csDown();

    // R10: busy then ready on the data output
    sendHdr(2'b01, 7'd0, 0);
    sendWord(pat(0));
    csDown();
    cs = 1'b1;
    repeat (4) @(negedge clk);
    check(oe0 && !do0, "R10 busy level", {oe0, do0}, 2);
    repeat (PC + 8) @(negedge clk);
    check(oe0 && do0, "R10 ready level", {oe0, do0}, 3);
    csDown();
    check(!oe0, "R9 released after status", oe0, 0);
    m0[0] = pat(0);
    m1[0] = pat(0);

    for (int a = 1; a < DEPTH; a++) begin
      doWrite(AB'(a), pat(a));
      m0[a] = pat(a);
      m1[a] = pat(a);
    end

    // R3/R4: continuous read across every word and the wrap
    readRun(7'd0, DEPTH + 1, 0);
    for (int a = 0; a < DEPTH; a++) begin
      check(r0[a] == m0[a], "R4 write sweep readback", r0[a], m0[a]);
    end
    check(r0[DEPTH] == m0[0], "R3 wrap to word 0", r0[DEPTH], m0[0]);

    // R11: the top address bit is ignored
    doWrite(7'h43, 8'hA5);
    m0[3] = 8'hA5;
    m1[3] = 8'hA5;
    readRun(7'h03, 1, 0);
    check(r0[0] == 8'hA5, "R11 alias low address", r0[0], 8'hA5);
    readRun(7'h43, 1, 0);
    check(r0[0] == 8'hA5, "R11 alias high address", r0[0], 8'hA5);

    // R5: erase one word
    sendHdr(2'b11, 7'd10, 0);
    csDown();
    waitProg();
    m0[10] = '1;
    m1[10] = '1;
    readRun(7'd10, 2, 0);
    check(r0[0] == 8'hFF, "R5 erased word", r0[0], 8'hFF);
    check(r0[1] == m0[11], "R5 neighbour untouched", r0[1], m0[11]);

    // R6: disable, then the write is ignored
    extCmd(2'b00);
    csDown();
    doWrite(7'd11, 8'h00);
    readRun(7'd11, 1, 0);
    check(r0[0] == m0[11], "R6 write after disable", r0[0], m0[11]);

    // R7/R8: write-all
    extCmd(2'b11);
    csDown();
    extCmd(2'b01);
    sendWord(8'h3C);
    csDown();
    waitProg();
    for (int a = 0; a < DEPTH; a++) m0[a] = 8'h3C;
    readRun(7'd0, DEPTH, 0);
    for (int a = 0; a < DEPTH; a++) begin
      check(r0[a] == m0[a], "R7 write-all", r0[a], m0[a]);
      check(r1[a] == m1[a], "R8 write-all disabled", r1[a], m1[a]);
    end

    // R7/R8: erase-all
    extCmd(2'b10);
    csDown();
    waitProg();
    for (int a = 0; a < DEPTH; a++) m0[a] = '1;
    readRun(7'd0, DEPTH, 0);
    for (int a = 0; a < DEPTH; a++) begin
      check(r0[a] == m0[a], "R7 erase-all", r0[a], m0[a]);
      check(r1[a] == m1[a], "R8 erase-all disabled", r1[a], m1[a]);
    end

    // R1: leading zeros before the start bit
    readRun(7'd20, 1, 3);
    check(r1[0] == m1[20], "R1 leading zeros u1", r1[0], m1[20]);
    check(r0[0] == m0[20], "R1 leading zeros u0", r0[0], m0[20]);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule